// File: doc/BRIEF.md
# Dual-Channel Converter Output Multiplexer

This block is the digital output stage of a two-channel sampling converter. Raw 10-bit codes for an in-phase (I) and a quadrature (Q) channel arrive on one conversion clock and are both taken on the same rising edge. Each channel then runs through its own fixed-latency pipeline. The I result lands on a rising edge. The Q result lands half a cycle later, on a falling edge.

The two results share one 10-bit output bus. A channel-select input chooses which channel drives the bus:
- Held steady, the select input gives one channel at single data rate.
- Tied to the clock, it gives I in the high phase and Q in the low phase of every cycle, so both channels leave on one bus at double data rate.

An active-low output enable releases the bus drivers while conversion carries on. The bus is provided in two forms:
- a tri-state port;
- a separate data and drive-enable pair, for targets that have no internal tri-state.

Top module: `dadc_out_mux`

## Requirements
- R1: Both channel inputs are captured on the same rising clock edge. The I code and Q code presented before rising edge k form sample k of each channel.
- R2: The I sample captured at rising edge k is presented on the bus right after rising edge k+7. It stays there until rising edge k+8.
- R3: The Q sample captured at rising edge k is presented right after the falling edge that follows rising edge k+7. It stays there until the next falling edge.
- R4: When sel_i is 1 the bus carries the I pipeline output. When sel_i is 0 it carries the Q pipeline output.
- R5: When sel_i is tied to the clock, each clock period shows the newest I sample during the high phase and the newest Q sample during the low phase.
- R6: While oe_ni is 1, drive_o is 0 and all ten bits of bus_o are high-impedance.
- R7: Output disable does not stop sampling. On return of oe_ni to 0, the bus shows at once the sample due in that cycle, with no sample skipped or repeated.
- R8: After reset, i_valid_o stays 0 until rising edge 8 and q_valid_o stays 0 until the falling edge after rising edge 8. While a channel is not valid, its selection drives all zeros. Once a valid flag rises it stays 1 until the next reset.
- R9: Code bits keep their positions end to end: input bit n appears on output bit n. Bit 9 is the MSB and bit 0 is the LSB. Every one of the 1024 codes passes unchanged.
- R10: data_o always carries the selected word. Whenever drive_o is 1, bus_o equals data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| i_code_i | input | 10 | Raw I-channel code |
| q_code_i | input | 10 | Raw Q-channel code |
| sel_i | input | 1 | Channel select: 1 selects I, 0 selects Q; may be tied to the clock |
| oe_ni | input | 1 | Output enable, active low |
| bus_o | output | 10 | Tri-state shared output bus |
| data_o | output | 10 | Selected word, without tri-state |
| drive_o | output | 1 | Bus drive enable |
| i_valid_o | output | 1 | I pipeline holds a real sample |
| q_valid_o | output | 1 | Q pipeline holds a real sample |

## Verification
The assertions run on every cycle and cover the following:
- each valid flag rises exactly when its fill count reaches the pipeline depth, and then stays high;
- Q validity never leads I validity;
- the bus never disagrees with data_o while driven.

Only the bench scenarios can show the exact half-cycle latency of each channel, the select polarity, and the interleaving with the select tied to the clock. The same holds for the sample continuity across a disable window. The bench shows these by comparing every half cycle against codes derived from the edge count, over a sweep that wraps through all 1024 codes.

// File: rtl/dadc_pkg.sv
package dadc_pkg;
  localparam int unsigned CODE_W   = 10;
  localparam int unsigned PIPE_LAT = 7;
endpackage

// File: rtl/dadc_delay_line.sv
module dadc_delay_line #(
  parameter int unsigned W     = 10,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o,
  output logic         v_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]     dat_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          dat_q[0] <= '0;
          vld_q    <= '0;
        end else begin
          dat_q[0] <= d_i;
          vld_q    <= 1'b1;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < int'(DEPTH); i++) dat_q[i] <= '0;
          vld_q <= '0;
        end else begin
          dat_q[0] <= d_i;
          for (int i = 1; i < int'(DEPTH); i++) dat_q[i] <= dat_q[i-1];
          vld_q <= {vld_q[DEPTH-2:0], 1'b1};
        end
      end
    end
  endgenerate

  assign d_o = dat_q[DEPTH-1];
  assign v_o = vld_q[DEPTH-1];

  // fill counter for the latency window check
  logic [CW-1:0] fill_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 fill_q <= '0;
    else if (fill_q != CW'(DEPTH)) fill_q <= fill_q + 1'b1;
  end

  p_fill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_o == (fill_q == CW'(DEPTH)));
  p_vld_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_o |=> v_o);
endmodule

// File: rtl/dadc_fall_stage.sv
module dadc_fall_stage #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic         v_i,
  output logic [W-1:0] d_o,
  output logic         v_o
);
  // launch half a cycle after the rising-edge pipeline
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_o <= '0;
      v_o <= 1'b0;
    end else begin
      d_o <= d_i;
      v_o <= v_i;
    end
  end
endmodule

// File: rtl/dadc_bus_mux.sv
module dadc_bus_mux #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_i,
  input  logic         oe_ni,
  input  logic [W-1:0] i_d_i,
  input  logic         i_v_i,
  input  logic [W-1:0] q_d_i,
  input  logic         q_v_i,
  output logic [W-1:0] data_o,
  output logic         drive_o,
  output logic [W-1:0] bus_o
);
  logic [W-1:0] i_word, q_word;

  assign i_word  = i_v_i ? i_d_i : '0;
  assign q_word  = q_v_i ? q_d_i : '0;
  assign data_o  = sel_i ? i_word : q_word;
  assign drive_o = ~oe_ni;
  assign bus_o   = drive_o ? data_o : {W{1'bz}};

  p_bus_match_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> bus_o == data_o);
endmodule

// File: rtl/dadc_out_mux.sv
module dadc_out_mux
  import dadc_pkg::*;
#(
  parameter int unsigned W   = CODE_W,
  parameter int unsigned LAT = PIPE_LAT
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] i_code_i,
  input  logic [W-1:0] q_code_i,
  input  logic         sel_i,
  input  logic         oe_ni,
  output logic [W-1:0] bus_o,
  output logic [W-1:0] data_o,
  output logic         drive_o,
  output logic         i_valid_o,
  output logic         q_valid_o
);
  // capture register plus LAT delay stages
  localparam int unsigned STAGES = LAT + 1;

  logic [W-1:0] i_line, q_line, q_late;
  logic         i_line_v, q_line_v, q_late_v;

  dadc_delay_line #(.W(W), .DEPTH(STAGES)) u_i_line (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(i_code_i),
    .d_o   (i_line), .v_o(i_line_v)
  );

  dadc_delay_line #(.W(W), .DEPTH(STAGES)) u_q_line (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(q_code_i),
    .d_o   (q_line), .v_o(q_line_v)
  );

  dadc_fall_stage #(.W(W)) u_q_fall (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(q_line), .v_i(q_line_v),
    .d_o  (q_late), .v_o(q_late_v)
  );

  dadc_bus_mux #(.W(W)) u_mux (
    .clk_i (clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .oe_ni(oe_ni),
    .i_d_i (i_line), .i_v_i(i_line_v),
    .q_d_i (q_late), .q_v_i(q_late_v),
    .data_o(data_o), .drive_o(drive_o), .bus_o(bus_o)
  );

  assign i_valid_o = i_line_v;
  assign q_valid_o = q_late_v;

  p_q_trails_i_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_o |-> i_valid_o);
  p_i_leads_q_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(i_valid_o) |-> q_valid_o);
endmodule

// File: tb/tb_dadc_out_mux.sv
`timescale 1ns/1ps
module tb_dadc_out_mux;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel_reg = 1'b1;
  logic         tied = 1'b0;
  logic         oe_n = 1'b0;
  logic         sel;
  logic [W-1:0] i_code, q_code;
  logic [W-1:0] bus, data;
  logic         drive, i_vld, q_vld;
  int           edge_cnt = 0;
  int           checks = 0;
  int           failures = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) edge_cnt <= 0;
    else        edge_cnt <= edge_cnt + 1;

  // sample k carries code k on I and its inverse on Q
  assign i_code = W'(edge_cnt + 1);
  assign q_code = ~W'(edge_cnt + 1);
  assign sel    = tied ? clk : sel_reg;

  dadc_out_mux dut (
    .clk_i(clk), .rst_ni(rst_n), .i_code_i(i_code), .q_code_i(q_code),
    .sel_i(sel), .oe_ni(oe_n), .bus_o(bus), .data_o(data),
    .drive_o(drive), .i_valid_o(i_vld), .q_valid_o(q_vld)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // high: sampled in the high phase after rising edge m
  task automatic check_half(input bit high);
    int m;
    bit s, iv, qv;
    logic [W-1:0] ie, qe, de;
    m  = edge_cnt;
    s  = tied ? high : sel_reg;
    iv = (m >= 8);
    ie = iv ? W'(m - 7) : '0;
    if (high) begin
      qv = (m >= 9);
      qe = qv ? ~W'(m - 8) : '0;
    end else begin
      qv = (m >= 8);
      qe = qv ? ~W'(m - 7) : '0;
    end
    de = s ? ie : qe;
    chk("R8 i_valid", int'(i_vld), int'(iv));
    chk("R8 q_valid", int'(q_vld), int'(qv));
    if (tied) chk("R5 interleave data", int'(data), int'(de));
    else if (s) chk("R2 R4 I latency", int'(data), int'(de));
    else chk("R3 R4 Q latency", int'(data), int'(de));
    chk("R6 drive_o", int'(drive), int'(!oe_n));
    if (!oe_n) chk("R10 R9 bus", int'(bus), int'(de));
  endtask

  task automatic run(input int n);
    for (int c = 0; c < n; c++) begin
      @(posedge clk); #1;
      check_half(1'b1);
      @(negedge clk); #1;
      check_half(1'b0);
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset data", int'(data), 0);
    chk("R8 reset i_valid", int'(i_vld), 0);
    chk("R8 reset q_valid", int'(q_vld), 0);
    @(negedge clk); #1;
    rst_n = 1'b1;
  endtask

  initial begin
    // R1 R2 R4 R8: steady select on I
    tied = 1'b0; sel_reg = 1'b1; oe_n = 1'b0;
    do_reset();
    run(40);
    // R1 R3 R4 R8: steady select on Q
    sel_reg = 1'b0;
    do_reset();
    run(40);
    // R5 R6 R7 R9 R10: select tied to clock, full code wrap, disable window
    tied = 1'b1;
    do_reset();
    run(300);
    @(negedge clk); #1;
    oe_n = 1'b1;
    run(40);
    chk("R6 drive released", int'(drive), 0);
    @(negedge clk); #1;
    oe_n = 1'b0;
    run(800);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule